// File: doc/BRIEF.md
# Pipeline Interlock Stall Scoreboard

This block sits at the issue point of an in-order pipeline. Each cycle it decides whether the instruction presented for issue has to wait. Every instruction arrives with a class code, up to two source register numbers, a destination register number and a few class-specific fields. The scoreboard keeps one countdown per architectural register, giving the cycles until that register's newest value can be consumed. A second countdown per register covers consumers that feed the value through the immediate shifter. Shared-resource timers cover the issue slot, the scalar multiplier, the SIMD multiplier and the memory port.

The wait for the presented instruction is the largest of all the timers that apply to it. While that wait is nonzero the block raises `stall` and reports the number of cycles still to go on `stall_cnt`. The instruction is accepted in the first cycle its wait is zero, and only then do its latencies enter the tables. Loads are treated as cache hits. A scalar multiply's data-dependent early termination arrives as a latency field with the instruction.

Top module: `stall_scoreboard`

## Requirements
- R1: After reset every timer is clear, so the first instruction presented issues with `stall` low and `stall_cnt` zero.
- R2: Class 0 (plain ALU; codes 10 to 15 behave the same) has a one-cycle result latency. A dependent instruction right behind it does not stall.
- R3: Class 1 (saturating ALU) delivers its result one cycle late. A dependent follower stalls 1 cycle and an independent follower stalls 0.
- R4: A class 2 consumer (ALU with immediate shift) reading source B waits one cycle longer than other consumers if that register was last written by class 0, 1, 2 or 3. Reading source A carries no extra wait.
- R5: Class 3 (ALU with register-held shift amount) stalls the next instruction 2 cycles whatever its sources. Its result has a three-cycle latency.
- R6: Class 4 (scalar multiply) takes its latency from `iss_mul_lat` (1 to 3, and 0 counts as 1). A dependent stalls latency-1 cycles, and so does the next class 4 or class 5 instruction.
- R7: Class 5 (flag-setting multiply) holds every following instruction. The next one stalls 4 cycles when the latency field is 3, otherwise 3 cycles. Its result is ready when that hold ends.
- R8: Class 6 (SIMD multiply) has a two-cycle result latency. The next class 6 instruction stalls 1 cycle even when it is independent.
- R9: Class 7 (word load) has a three-cycle result latency, so a dependent follower stalls 2 cycles.
- R10: Class 8 (double load) makes the destination ready after 4 cycles. With `iss_pair` set, the destination is ready after 3 cycles and destination+1 (mod register count) after 4. The next memory instruction (class 7, 8 or 9) stalls 1 cycle, and non-memory instructions are not held by this.
- R11: Class 9 (multi-register load) stalls the next instruction 1 + `iss_xfer` cycles.
- R12: `stall` is high exactly when `iss_valid` is high and the wait is nonzero. `stall_cnt` equals that wait, or zero when no instruction is presented. While the same instruction is held, `stall_cnt` falls by one each cycle, and tables change only on `issue`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_class | input | 4 | Class code (see requirements) |
| iss_src_a | input | RW | Source A register number |
| iss_src_a_en | input | 1 | Source A is read |
| iss_src_b | input | RW | Source B register number (shifted operand) |
| iss_src_b_en | input | 1 | Source B is read |
| iss_dst | input | RW | Destination register number |
| iss_dst_en | input | 1 | Destination is written |
| iss_pair | input | 1 | Double load writes a register pair |
| iss_mul_lat | input | 2 | Scalar multiply latency, 1 to 3 |
| iss_xfer | input | XW | Register count of a multi-register load |
| stall | output | 1 | Presented instruction must wait |
| stall_cnt | output | CW | Cycles of waiting still required |
| issue | output | 1 | Presented instruction is accepted this cycle |

## Verification
A register countdown that is loaded wrongly or never decremented shows up at the first dependent instruction presented after its producer. It appears as a wrong `stall_cnt` in that very cycle, or as a countdown that skips or repeats a value on later held cycles. A resource timer fault shows up only when a follower of the matching class is presented. The random stream therefore keeps register numbers few and class mixes dense, so that most accepted instructions are followed within a cycle or two by a consumer that reads back the timer they touched.

// File: rtl/stall_scoreboard.sv
module stall_scoreboard #(
  parameter int NREG = 16,
  parameter int XW   = 5,
  localparam int RW  = $clog2(NREG),
  localparam int CW  = XW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [3:0]    iss_class,
  input  logic [RW-1:0] iss_src_a,
  input  logic          iss_src_a_en,
  input  logic [RW-1:0] iss_src_b,
  input  logic          iss_src_b_en,
  input  logic [RW-1:0] iss_dst,
  input  logic          iss_dst_en,
  input  logic          iss_pair,
  input  logic [1:0]    iss_mul_lat,
  input  logic [XW-1:0] iss_xfer,
  output logic          stall,
  output logic [CW-1:0] stall_cnt,
  output logic          issue
);

  localparam logic [3:0] C_ALU   = 4'd0;
  localparam logic [3:0] C_SAT   = 4'd1;
  localparam logic [3:0] C_SHIMM = 4'd2;
  localparam logic [3:0] C_SHREG = 4'd3;
  localparam logic [3:0] C_MUL   = 4'd4;
  localparam logic [3:0] C_MULF  = 4'd5;
  localparam logic [3:0] C_SMUL  = 4'd6;
  localparam logic [3:0] C_LDW   = 4'd7;
  localparam logic [3:0] C_LDD   = 4'd8;
  localparam logic [3:0] C_LDM   = 4'd9;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] x);
    return (x == '0) ? '0 : x - CW'(1);
  endfunction

  function automatic logic [CW-1:0] mx(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [CW-1:0] rdy [NREG];
  logic [CW-1:0] shr [NREG];
  logic [CW-1:0] blk_q, mul_q, smul_q, mem_q;

  wire is_mulc = (iss_class == C_MUL) || (iss_class == C_MULF);
  wire is_mem  = (iss_class == C_LDW) || (iss_class == C_LDD) || (iss_class == C_LDM);

  wire [1:0] mlat = (iss_mul_lat == 2'd0) ? 2'd1 : iss_mul_lat;
  wire [CW-1:0] fhold = (mlat == 2'd3) ? CW'(4) : CW'(3);

  logic [CW-1:0] w_a, w_b, w_res, need;
  assign w_a = iss_src_a_en ? rdy[iss_src_a] : '0;
  assign w_b = !iss_src_b_en ? '0 :
               (iss_class == C_SHIMM) ? shr[iss_src_b] : rdy[iss_src_b];
  assign w_res = mx(is_mulc ? mul_q : '0,
                 mx((iss_class == C_SMUL) ? smul_q : '0, is_mem ? mem_q : '0));
  assign need = mx(mx(w_a, w_b), mx(w_res, blk_q));

  assign stall     = iss_valid && (need != '0);
  assign stall_cnt = iss_valid ? need : '0;
  assign issue     = iss_valid && (need == '0);

  logic [CW-1:0] va, blk_new;
  logic          alu_fam;
  always_comb begin
    va      = '0;
    blk_new = '0;
    alu_fam = 1'b0;
    case (iss_class)
      C_SAT:   begin va = CW'(1); alu_fam = 1'b1; end
      C_SHIMM: begin va = '0;     alu_fam = 1'b1; end
      C_SHREG: begin va = CW'(2); alu_fam = 1'b1; blk_new = CW'(2); end
      C_MUL:   va = CW'(mlat) - CW'(1);
      C_MULF:  begin va = fhold; blk_new = fhold; end
      C_SMUL:  va = CW'(1);
      C_LDW:   va = CW'(2);
      C_LDD:   va = iss_pair ? CW'(2) : CW'(3);
      C_LDM:   blk_new = CW'(iss_xfer) + CW'(1);
      default: begin va = '0; alu_fam = 1'b1; end
    endcase
  end

  wire [CW-1:0] sa    = alu_fam ? va + CW'(1) : va;
  wire          wr_a  = issue && iss_dst_en && (iss_class != C_LDM);
  wire          wr_b  = issue && iss_dst_en && (iss_class == C_LDD) && iss_pair;
  wire [RW-1:0] dst2  = (32'(iss_dst) + 1 >= NREG) ? '0 : iss_dst + RW'(1);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rdy[g] <= '0;
        shr[g] <= '0;
      end else if (wr_b && dst2 == RW'(g)) begin
        rdy[g] <= CW'(3);
        shr[g] <= CW'(3);
      end else if (wr_a && iss_dst == RW'(g)) begin
        rdy[g] <= va;
        shr[g] <= sa;
      end else begin
        rdy[g] <= dec(rdy[g]);
        shr[g] <= dec(shr[g]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '0;
      mul_q  <= '0;
      smul_q <= '0;
      mem_q  <= '0;
    end else begin
      blk_q  <= issue ? blk_new : dec(blk_q);
      mul_q  <= (issue && is_mulc) ? CW'(mlat) - CW'(1) : dec(mul_q);
      smul_q <= (issue && iss_class == C_SMUL) ? CW'(1) : dec(smul_q);
      mem_q  <= (issue && iss_class == C_LDD) ? CW'(1) : dec(mem_q);
    end
  end

  AST_SAT_DEP: assert property (@(posedge clk) disable iff (!rst_n)
    issue && iss_class == C_SAT && iss_dst_en |=>
      (!(iss_valid && iss_src_a_en && iss_src_a == $past(iss_dst)) || stall)); // R3

  AST_SHREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    issue && iss_class == C_SHREG |=> (!iss_valid || stall_cnt >= CW'(2))); // R5

  AST_FLAGMUL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    issue && iss_class == C_MULF |=> (!iss_valid || stall_cnt >= CW'(3))); // R7

  AST_DBL_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    issue && iss_class == C_LDD |=> (!(iss_valid && is_mem) || stall)); // R10

  AST_MULTI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    issue && iss_class == C_LDM |=>
      (!iss_valid || stall_cnt >= CW'($past(iss_xfer)) + CW'(1))); // R11

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!(iss_valid && $stable({iss_class, iss_src_a, iss_src_a_en, iss_src_b, iss_src_b_en}))
               || stall_cnt == $past(stall_cnt) - CW'(1))); // R12

endmodule

// File: tb/stall_scoreboard_test.sv
module stall_scoreboard_test;
  localparam int NREG = 16;
  localparam int XW   = 5;
  localparam int RW   = 4;
  localparam int CW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [3:0] iss_class = '0;
  logic [RW-1:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
  logic iss_src_a_en = 1'b0, iss_src_b_en = 1'b0, iss_dst_en = 1'b0, iss_pair = 1'b0;
  logic [1:0] iss_mul_lat = '0;
  logic [XW-1:0] iss_xfer = '0;
  logic stall, issue;
  logic [CW-1:0] stall_cnt;

  stall_scoreboard #(.NREG(NREG), .XW(XW)) uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
    .iss_src_a(iss_src_a), .iss_src_a_en(iss_src_a_en),
    .iss_src_b(iss_src_b), .iss_src_b_en(iss_src_b_en),
    .iss_dst(iss_dst), .iss_dst_en(iss_dst_en), .iss_pair(iss_pair),
    .iss_mul_lat(iss_mul_lat), .iss_xfer(iss_xfer),
    .stall(stall), .stall_cnt(stall_cnt), .issue(issue));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int rdyT[NREG], shT[NREG];
  int blkT = 0, mulT = 0, smulT = 0, memT = 0;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int model_wait(input int c, input int a, input bit ae, input int b, input bit be);
    int w;
    w = blkT - cyc;
    if (ae) w = mx(w, rdyT[a] - cyc);
    if (be) w = mx(w, ((c == 2) ? shT[b] : rdyT[b]) - cyc);
    if (c == 4 || c == 5) w = mx(w, mulT - cyc);
    if (c == 6) w = mx(w, smulT - cyc);
    if (c >= 7 && c <= 9) w = mx(w, memT - cyc);
    return mx(w, 0);
  endfunction

  task automatic model_issue(input int c, input int d, input bit de, input int lat, input int n, input bit pr);
    int t, eff, hold, lr;
    bit fam;
    t = cyc;
    eff = (lat == 0) ? 1 : lat;
    hold = (eff == 3) ? 4 : 3;
    fam = 1'b0;
    case (c)
      1: begin lr = 2; fam = 1'b1; end
      2: begin lr = 1; fam = 1'b1; end
      3: begin lr = 3; fam = 1'b1; blkT = t + 3; end
      4: lr = eff;
      5: begin lr = hold + 1; blkT = t + 1 + hold; end
      6: lr = 2;
      7: lr = 3;
      8: lr = pr ? 3 : 4;
      9: begin lr = 0; blkT = t + 2 + n; end
      default: begin lr = 1; fam = 1'b1; end
    endcase
    if (de && c != 9) begin
      rdyT[d] = t + lr;
      shT[d] = t + lr + (fam ? 1 : 0);
      if (c == 8 && pr) begin
        rdyT[(d + 1) % NREG] = t + 4;
        shT[(d + 1) % NREG] = t + 4;
      end
    end
    if (c == 4 || c == 5) mulT = t + eff;
    if (c == 6) smulT = t + 2;
    if (c == 8) memT = t + 2;
  endtask

  function automatic string tag_of(input int c);
    case (c)
      1: return "R3"; 2: return "R4"; 3: return "R5"; 4: return "R6";
      5: return "R7"; 6: return "R8"; 7: return "R9"; 8: return "R10";
      9: return "R11"; default: return "R2";
    endcase
  endfunction

  task automatic bubble(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      iss_valid = 1'b0;
      #1;
      chk(int'(stall), 0, "R12 idle stall");
      chk(int'(stall_cnt), 0, "R12 idle count");
    end
  endtask

  task automatic run(input int c, input int a, input bit ae, input int b, input bit be,
                     input int d, input bit de, input int lat, input int n, input bit pr,
                     input int exp0, input string tag);
    int ew;
    bit first;
    first = 1'b1;
    for (int g = 0; g < 64; g++) begin
      @(negedge clk);
      iss_valid = 1'b1; iss_class = 4'(c);
      iss_src_a = RW'(a); iss_src_a_en = ae; iss_src_b = RW'(b); iss_src_b_en = be;
      iss_dst = RW'(d); iss_dst_en = de; iss_mul_lat = 2'(lat); iss_xfer = XW'(n); iss_pair = pr;
      #1;
      ew = model_wait(c, a, ae, b, be);
      if (first && exp0 >= 0) chk(int'(stall_cnt), exp0, tag);
      chk(int'(stall_cnt), ew, first ? tag : "R12 countdown");
      chk(int'(stall), (ew != 0) ? 1 : 0, "R12 stall flag");
      first = 1'b0;
      if (ew == 0) begin
        model_issue(c, d, de, lat, n, pr);
        break;
      end
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin rdyT[i] = 0; shT[i] = 0; end
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(int'(stall), 0, "R1 reset stall");
    chk(int'(stall_cnt), 0, "R1 reset count");
    run(7, 3, 1, 4, 1, 5, 1, 0, 0, 0, 0, "R1 first after reset");
    bubble(6);
    run(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, -1, "R2");
    run(0, 1, 1, 1, 1, 2, 1, 0, 0, 0, 0, "R2 dependent");
    bubble(4);
    run(1, 0, 0, 0, 0, 2, 1, 0, 0, 0, -1, "R3");
    run(0, 2, 1, 0, 0, 9, 1, 0, 0, 0, 1, "R3 dependent");
    bubble(4);
    run(1, 0, 0, 0, 0, 3, 1, 0, 0, 0, -1, "R3");
    run(0, 5, 1, 0, 0, 9, 1, 0, 0, 0, 0, "R3 independent");
    bubble(4);
    run(0, 0, 0, 0, 0, 4, 1, 0, 0, 0, -1, "R4");
    run(2, 0, 0, 4, 1, 9, 1, 0, 0, 0, 1, "R4 shifted source");
    bubble(4);
    run(0, 0, 0, 0, 0, 4, 1, 0, 0, 0, -1, "R4");
    run(2, 4, 1, 0, 0, 9, 1, 0, 0, 0, 0, "R4 unshifted source");
    bubble(4);
    run(3, 0, 0, 0, 0, 5, 1, 0, 0, 0, -1, "R5");
    run(0, 9, 1, 0, 0, 10, 1, 0, 0, 0, 2, "R5 independent");
    bubble(4);
    run(4, 0, 0, 0, 0, 6, 1, 3, 0, 0, -1, "R6");
    run(0, 6, 1, 0, 0, 9, 1, 0, 0, 0, 2, "R6 dependent");
    bubble(4);
    run(4, 0, 0, 0, 0, 6, 1, 3, 0, 0, -1, "R6");
    run(4, 10, 1, 11, 1, 12, 1, 1, 0, 0, 2, "R6 multiplier busy");
    bubble(4);
    run(4, 0, 0, 0, 0, 6, 1, 0, 0, 0, -1, "R6");
    run(0, 6, 1, 0, 0, 9, 1, 0, 0, 0, 0, "R6 zero latency field");
    bubble(4);
    run(5, 0, 0, 0, 0, 6, 1, 3, 0, 0, -1, "R7");
    run(0, 9, 1, 0, 0, 10, 1, 0, 0, 0, 4, "R7 long hold");
    bubble(6);
    run(5, 0, 0, 0, 0, 6, 1, 1, 0, 0, -1, "R7");
    run(0, 9, 1, 0, 0, 10, 1, 0, 0, 0, 3, "R7 short hold");
    bubble(6);
    run(6, 0, 0, 0, 0, 7, 1, 0, 0, 0, -1, "R8");
    run(6, 1, 1, 2, 1, 12, 1, 0, 0, 0, 1, "R8 unit busy");
    bubble(4);
    run(6, 0, 0, 0, 0, 7, 1, 0, 0, 0, -1, "R8");
    run(0, 7, 1, 0, 0, 9, 1, 0, 0, 0, 1, "R8 dependent");
    bubble(4);
    run(7, 0, 0, 0, 0, 8, 1, 0, 0, 0, -1, "R9");
    run(0, 8, 1, 0, 0, 9, 1, 0, 0, 0, 2, "R9 dependent");
    bubble(4);
    run(8, 0, 0, 0, 0, 8, 1, 0, 0, 0, -1, "R10");
    run(0, 8, 1, 0, 0, 9, 1, 0, 0, 0, 3, "R10 single dependent");
    bubble(6);
    run(8, 0, 0, 0, 0, 10, 1, 0, 0, 1, -1, "R10");
    run(0, 10, 1, 0, 0, 9, 1, 0, 0, 0, 2, "R10 pair low");
    bubble(6);
    run(8, 0, 0, 0, 0, 10, 1, 0, 0, 1, -1, "R10");
    run(0, 11, 1, 0, 0, 9, 1, 0, 0, 0, 3, "R10 pair high");
    bubble(6);
    run(8, 0, 0, 0, 0, 12, 1, 0, 0, 0, -1, "R10");
    run(7, 1, 1, 0, 0, 13, 1, 0, 0, 0, 1, "R10 port hazard");
    bubble(6);
    run(8, 0, 0, 0, 0, 12, 1, 0, 0, 0, -1, "R10");
    run(0, 1, 1, 0, 0, 13, 1, 0, 0, 0, 0, "R10 non-memory follower");
    bubble(6);
    run(9, 0, 0, 0, 0, 0, 0, 0, 4, 0, -1, "R11");
    run(0, 1, 1, 0, 0, 13, 1, 0, 0, 0, 5, "R11 four registers");
    bubble(8);
    run(9, 0, 0, 0, 0, 0, 0, 0, 0, 0, -1, "R11");
    run(0, 1, 1, 0, 0, 13, 1, 0, 0, 0, 1, "R11 zero registers");
    bubble(4);
    for (int k = 0; k < 400; k++) begin
      int c;
      c = int'($urandom_range(0, 11));
      if ($urandom_range(0, 7) == 0) bubble(1);
      run(c, int'($urandom_range(0, 5)), 1'($urandom_range(0, 1)),
          int'($urandom_range(0, 5)), 1'($urandom_range(0, 1)),
          int'($urandom_range(0, 5)), 1'($urandom_range(0, 3) != 0),
          int'($urandom_range(0, 3)), int'($urandom_range(0, 6)),
          1'($urandom_range(0, 1)), -1, tag_of(c));
    end
    bubble(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule